// File: doc/BRIEF.md
# Bus Wait-State Generator

This block lengthens external bus accesses so that slow off-chip devices can respond. Each of three off-chip address spaces (program, data, I/O) has its own programmable software wait count from zero to seven. The block inserts these wait states unconditionally. After they are used up, a ready input from the external device can hold the access for any number of further clocks.

The core signals the start of an access with a one-clock strobe and a space code. In the same clock, the block tells the core to hold (`stall`) or reports that the access is complete (`acc_done`). Back-pressure works like this: the core keeps the access on the bus for as long as `stall` is high, and it may launch the next access in any cycle in which the block is idle, including the cycle right after `acc_done`. The software counts are loaded through a plain register write port. Each count is captured when an access starts, so writes made during an access affect only later accesses.

Top module: `bus_wait_gen`

## Requirements
- R1: The wait counts are written as one 9-bit word when `cfg_we` is high, taking effect at that clock edge. Bits [2:0] hold the program count (space code 0), bits [5:3] the data count (code 1) and bits [8:6] the I/O count (code 2). The three counts are independent. An access started in the same cycle as a write uses the old count.
- R2: Reset (`rst_n` low, asynchronous) sets every count to 7 and returns the block to idle, with `stall` and `acc_done` low.
- R3: An access whose selected count W is nonzero holds `stall` high for clocks 0..W-1, counted from the start cycle. This happens whatever level `rdy_in` has.
- R4: From clock W onward, `rdy_in` is sampled each clock. While it is low, `stall` stays high for that clock and the check repeats in the next clock. The access completes in the first clock at or after W in which `rdy_in` is high.
- R5: With W = 0, the access completes in its start cycle: `acc_done` is high and `stall` is low, and `rdy_in` is ignored.
- R6: `stall` is combinationally high in the start cycle whenever W is nonzero. `stall` and `acc_done` are never high together.
- R7: `acc_done` is high for exactly one clock per access, in its completion cycle, and `stall` is low in that cycle.
- R8: `acc_start` is accepted only while the block is idle. A strobe during an access, including the completion cycle of a waited access, is ignored and does not change the timing.
- R9: Space code 3 selects no count and gives an access with zero software waits.
- R10: The count is captured at the start of an access. A configuration write during the access leaves its length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start | input | 1 | One-clock access start strobe |
| acc_space | input | 2 | Space code: 0 program, 1 data, 2 I/O, 3 none |
| cfg_we | input | 1 | Wait-count register write enable |
| cfg_wdata | input | 9 | Packed wait counts, three 3-bit fields |
| rdy_in | input | 1 | External device ready |
| stall | output | 1 | Hold request to the core |
| acc_done | output | 1 | Access completion pulse |

## Verification
The assertions check on every cycle that:
- `stall` and `acc_done` stay exclusive;
- a low ready in the sampling phase keeps the access open;
- the software counter never underflows;
- a register write lands in the right field;
- a busy block never reloads its counter;
- an unused space code finishes at once.

Only the bench's scenarios can show the exact access length. It sweeps every space, every count 0 to 7 and several ready-low runs, with ready both low and high during the software waits. The same approach shows that writes in flight do not shorten an access, and that strobes during an access change nothing.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int unsigned NUM_SPACES = 3;
  localparam int unsigned WAIT_W     = 3;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned CFG_W      = NUM_SPACES * WAIT_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SOFT  = 2'd1,
    ST_READY = 2'd2
  } bwg_state_e;
endpackage

// File: rtl/bwg_cfg_regs.sv
module bwg_cfg_regs
  import bwg_pkg::*;
#(
  parameter int unsigned NSP = NUM_SPACES,
  parameter int unsigned WW  = WAIT_W,
  parameter int unsigned SW  = SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [NSP*WW-1:0] cfg_wdata,
  input  logic [SW-1:0]    sel,
  output logic [WW-1:0]    sel_wait
);
  logic [WW-1:0] cnt_q [NSP];

  for (genvar g = 0; g < NSP; g++) begin : g_space
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[g] <= '1;
      else if (cfg_we) cnt_q[g] <= cfg_wdata[g*WW +: WW];
    end

    // R1: each field lands in its own register
    a_r1_field_write: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cnt_q[g] == $past(cfg_wdata[g*WW +: WW])));
  end

  // Unused codes select zero waits (R9)
  always_comb begin
    sel_wait = '0;
    for (int i = 0; i < NSP; i++) begin
      if (sel == SW'(i)) sel_wait = cnt_q[i];
    end
  end
endmodule

// File: rtl/bwg_soft_cnt.sv
module bwg_soft_cnt
  import bwg_pkg::*;
#(
  parameter int unsigned WW = WAIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - WW'(1);
  end

  assign last = (cnt_q == WW'(1));

  // R3: software waits never run the counter below zero
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt_q == $past(cnt_q) - WW'(1)));
endmodule

// File: rtl/bwg_ctrl.sv
module bwg_ctrl
  import bwg_pkg::*;
#(
  parameter int unsigned WW = WAIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_start,
  input  logic          rdy_in,
  input  logic          cnt_last,
  input  logic [WW-1:0] sel_wait,
  output logic          stall,
  output logic          acc_done,
  output logic          cnt_load,
  output logic          cnt_dec,
  output logic [WW-1:0] cnt_load_val,
  output logic          idle
);
  bwg_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d         = st_q;
    stall        = 1'b0;
    acc_done     = 1'b0;
    cnt_load     = 1'b0;
    cnt_dec      = 1'b0;
    cnt_load_val = sel_wait - WW'(1);
    case (st_q)
      ST_IDLE: begin
        if (acc_start) begin
          if (sel_wait == '0) begin
            acc_done = 1'b1;
          end else begin
            stall    = 1'b1;
            cnt_load = 1'b1;
            st_d     = (sel_wait == WW'(1)) ? ST_READY : ST_SOFT;
          end
        end
      end
      ST_SOFT: begin
        stall   = 1'b1;
        cnt_dec = 1'b1;
        if (cnt_last) st_d = ST_READY;
      end
      ST_READY: begin
        if (rdy_in) begin
          acc_done = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          stall = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign idle = (st_q == ST_IDLE);

  // R4: a low ready keeps the access open for another clock
  a_r4_hold_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READY && !rdy_in) |=> (st_q == ST_READY));

  // R3: software phase always stalls and never completes
  a_r3_soft_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SOFT) |-> (stall && !acc_done));

  // R8: a busy block never restarts its counter
  a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !cnt_load);
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_start,
  input  logic [SEL_W-1:0] acc_space,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             rdy_in,
  output logic             stall,
  output logic             acc_done
);
  logic [WAIT_W-1:0] sel_wait;
  logic [WAIT_W-1:0] load_val;
  logic              cnt_load, cnt_dec, cnt_last, idle;

  bwg_cfg_regs #(.NSP(NUM_SPACES), .WW(WAIT_W), .SW(SEL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .sel      (acc_space),
    .sel_wait (sel_wait)
  );

  bwg_soft_cnt #(.WW(WAIT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(load_val),
    .dec     (cnt_dec),
    .last    (cnt_last)
  );

  bwg_ctrl #(.WW(WAIT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_start   (acc_start),
    .rdy_in      (rdy_in),
    .cnt_last    (cnt_last),
    .sel_wait    (sel_wait),
    .stall       (stall),
    .acc_done    (acc_done),
    .cnt_load    (cnt_load),
    .cnt_dec     (cnt_dec),
    .cnt_load_val(load_val),
    .idle        (idle)
  );

  // R6: hold and completion are exclusive
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && acc_done));

  // R7: a completion pulse is followed only by a fresh zero-wait completion
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> (!acc_done || acc_start));

  // R9: an unmapped space code completes immediately
  a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && acc_start && acc_space >= SEL_W'(NUM_SPACES)) |-> (acc_done && !stall));
endmodule

// File: tb/sim_bus_wait_gen.sv
`timescale 1ns/1ps
module sim_bus_wait_gen;
  import bwg_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_start = 1'b0;
  logic [SEL_W-1:0] acc_space = '0;
  logic             cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             rdy_in = 1'b1;
  logic             stall, acc_done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_wait_gen u0 (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_space(acc_space),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rdy_in(rdy_in),
    .stall(stall), .acc_done(acc_done)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [CFG_W-1:0] pack(input int p, input int d, input int io);
    pack = {WAIT_W'(io), WAIT_W'(d), WAIT_W'(p)};
  endfunction

  task automatic write_cfg(input logic [CFG_W-1:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; total = cycles of stall, completion in cycle total
  task automatic run_access(input logic [SEL_W-1:0] sp, input int w, input int lows,
                            input logic sw_rdy, input bit poke, input string req);
    int total;
    total = (w == 0) ? 0 : w + lows;
    @(negedge clk);
    acc_start = 1'b1;
    acc_space = sp;
    for (int k = 0; k <= total; k++) begin
      if (k > 0) begin
        @(negedge clk);
        acc_start = poke;          // R8 strobes while busy
        acc_space = 2'd3;
      end
      rdy_in = (k < w) ? sw_rdy : ((k < w + lows) ? 1'b0 : 1'b1);
      if (w == 0) rdy_in = (lows > 0) ? 1'b0 : 1'b1;   // R5 ready ignored
      #1;
      chk(req, "stall", stall, logic'(k < total));
      chk(req, "done", acc_done, logic'(k == total));
    end
    @(negedge clk);
    acc_start = 1'b0;
    rdy_in = 1'b1;
    #1;
    chk(req, "idle stall", stall, 1'b0);
    chk(req, "idle done", acc_done, 1'b0);   // R7 single pulse
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "reset stall", stall, 1'b0);
    chk("R2", "reset done", acc_done, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 default counts of 7 in every space
    for (int s = 0; s < NUM_SPACES; s++) run_access(SEL_W'(s), 7, 0, 1'b0, 1'b0, "R2");

    // R1 R3 R4 R5 R6 sweep over space, count, ready-low run, ready level in soft phase
    for (int s = 0; s < NUM_SPACES; s++)
      for (int w = 0; w < 8; w++)
        for (int l = 0; l < 3; l++) begin
          logic [CFG_W-1:0] word;
          word = pack(7 - w, 7 - w, 7 - w);
          word[s*WAIT_W +: WAIT_W] = WAIT_W'(w);
          write_cfg(word);
          run_access(SEL_W'(s), w, l, logic'((w + l) % 2), 1'b0, "R1 R3 R4 R5 R6");
        end

    // R1 independent fields
    write_cfg(pack(2, 5, 0));
    run_access(2'd0, 2, 1, 1'b0, 1'b0, "R1");
    run_access(2'd1, 5, 0, 1'b1, 1'b0, "R1");
    run_access(2'd2, 0, 1, 1'b0, 1'b0, "R1");

    // R9 unmapped code
    run_access(2'd3, 0, 2, 1'b0, 1'b0, "R9");

    // R8 strobes during an access are ignored
    write_cfg(pack(4, 1, 3));
    run_access(2'd0, 4, 2, 1'b1, 1'b1, "R8");
    run_access(2'd1, 1, 1, 1'b0, 1'b1, "R8");

    // R10 and R1: write in the start cycle and mid-access, length stays 4
    write_cfg(pack(4, 4, 4));
    @(negedge clk);
    acc_start = 1'b1;
    acc_space = 2'd0;
    cfg_we = 1'b1;
    cfg_wdata = pack(1, 1, 1);
    rdy_in = 1'b1;
    for (int k = 0; k <= 4; k++) begin
      if (k > 0) begin
        @(negedge clk);
        acc_start = 1'b0;
        cfg_we = (k == 2);
        cfg_wdata = pack(0, 0, 0);
      end
      #1;
      chk("R10", "stall", stall, logic'(k < 4));
      chk("R10", "done", acc_done, logic'(k == 4));
    end
    @(negedge clk);
    cfg_we = 1'b0;
    // last write set program count to 0
    run_access(2'd0, 0, 1, 1'b0, 1'b0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule